// File: doc/BRIEF.md
# Opcode Substitution Call Unit

This block sits between a 6502-family processor's data bus and cartridge program memory. It watches every bus read cycle and has the option to put its own byte on the bus in place of memory. One reserved opcode value (`8'h02`), fetched as an opcode from cartridge space, becomes an indirect call. In that same cycle the unit places the indirect-jump opcode `8'h6C` on the bus. It also pushes the fetch address plus three onto a small return store. The processor then reads the two pointer bytes (low, then high) from program memory unchanged and jumps through them.

A later return opcode (`8'h60`) fetched from cartridge space while the store holds an entry is rewritten into an absolute jump. In that case the unit drives `8'h4C`, then the low byte of the newest stored address, then its high byte, over three bus cycles. Program memory stays disabled across all three. The entry is popped after the high byte. A return with an empty store passes through untouched, so ordinary subroutine returns keep working. The processor itself is unchanged.

The bus interface is a plain per-cycle strobe with no back-pressure. The processor never waits, so each cycle with `bus_en` high is one read that must be answered combinationally in that cycle. Cycles with `bus_en` low carry no transfer and do not advance the unit.

Top module: `osc_call_unit`

## Requirements
- R1: After reset, `sub_oe` is 0, `prg_en` is 1, and the return store is empty.
- R2: In a bus cycle with `bus_en`=1, `sync`=1, `cpu_addr` >= `CART_BASE` and `prg_data`=`8'h02`, the unit drives `sub_data`=`8'h6C` with `sub_oe`=1 and `prg_en`=0 in that same cycle.
- R3: That trigger pushes (`cpu_addr`+3) mod 2^16 onto the return store.
- R4: The two bus cycles after a trigger (pointer low and high bytes, `sync`=0) pass through: `sub_oe`=0, `prg_en`=1.
- R5: A cartridge-space opcode fetch of `8'h60` with a non-empty store drives `8'h4C`, then the stored low byte, then the stored high byte, on three consecutive bus cycles. Each of these has `sub_oe`=1 and `prg_en`=0, and the entry is popped after the third.
- R6: A `8'h60` opcode fetch with an empty store passes through (`sub_oe`=0, `prg_en`=1).
- R7: Opcode fetches below `CART_BASE` are never substituted and push nothing.
- R8: Reads with `sync`=0 are never treated as triggers or returns, whatever the data.
- R9: Nested calls return in last-in, first-out order.
- R10: The store holds `DEPTH` (default 4) entries. A push when it is full drops the oldest entry.
- R11: Cycles with `bus_en`=0 leave the jump sequence where it is and keep `sub_oe`=0.
- R12: `sub_oe` and `prg_en` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | High in a cycle that carries one processor read |
| sync | input | 1 | High when the read is an opcode fetch |
| cpu_addr | input | ADDR_W | Processor address |
| prg_data | input | 8 | Byte read from program memory |
| sub_data | output | 8 | Substitute byte toward the processor |
| sub_oe | output | 1 | Substitute byte is driven |
| prg_en | output | 1 | Program memory may drive the bus |

## Verification
A single call followed by a single return checks the indirect opcode and the pushed address plus three. The same pair exposes the byte order of the three jump bytes. A return with an empty store, a trigger value placed below the cartridge base, and trigger and return values read as operands (not opcodes) show that substitution needs all three conditions together. Nested calls separate last-in, first-out from first-in, first-out. Five calls with five returns show whether the oldest or the newest entry is lost on overflow. An idle cycle in the middle of a jump shows whether the sequence is counted in bus cycles or in clocks.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam logic [7:0] OP_TRIGGER = 8'h02;
  localparam logic [7:0] OP_RETURN  = 8'h60;
  localparam logic [7:0] OP_JMP_IND = 8'h6C;
  localparam logic [7:0] OP_JMP_ABS = 8'h4C;

  typedef enum logic [2:0] {
    SEL_PASS,
    SEL_IND,
    SEL_JMP,
    SEL_LO,
    SEL_HI
  } sel_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LO,
    ST_HI
  } seq_t;
endpackage

// File: rtl/osc_ret_stack.sv
module osc_ret_stack #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [ADDR_W-1:0] top_addr,
  output logic              nonempty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr;
  logic [PW-1:0]     top_ptr;

  assign top_ptr  = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;
  assign top_addr = mem[top_ptr];
  assign nonempty = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      count  <= '0;
    end else if (push) begin
      wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (count != FULL) count <= count + 1'b1;
    end else if (pop && nonempty) begin
      wr_ptr <= top_ptr;
      count  <= count - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == PW'(i)) mem[i] <= push_addr;
    end
  end
endmodule

// File: rtl/osc_seq.sv
module osc_seq
  import osc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       sync,
  input  logic       in_cart,
  input  logic [7:0] prg_data,
  input  logic       nonempty,
  output logic       push,
  output logic       pop,
  output sel_t       sel,
  output logic       busy
);
  seq_t state, state_nx;
  logic opfetch;

  assign opfetch = bus_en && sync && in_cart && (state == ST_IDLE);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    sel      = SEL_PASS;
    push     = 1'b0;
    pop      = 1'b0;
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (opfetch && prg_data == OP_TRIGGER) begin
          sel  = SEL_IND;
          push = 1'b1;
        end else if (opfetch && prg_data == OP_RETURN && nonempty) begin
          sel      = SEL_JMP;
          state_nx = ST_LO;
        end
      end
      ST_LO: begin
        sel = SEL_LO;
        if (bus_en) state_nx = ST_HI;
      end
      ST_HI: begin
        sel = SEL_HI;
        if (bus_en) begin
          pop      = 1'b1;
          state_nx = ST_IDLE;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/osc_bus_mux.sv
module osc_bus_mux
  import osc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              bus_en,
  input  sel_t              sel,
  input  logic [ADDR_W-1:0] top_addr,
  output logic [7:0]        sub_data,
  output logic              sub_oe,
  output logic              prg_en
);
  logic drive;

  always_comb begin
    unique case (sel)
      SEL_IND: sub_data = OP_JMP_IND;
      SEL_JMP: sub_data = OP_JMP_ABS;
      SEL_LO:  sub_data = top_addr[7:0];
      SEL_HI:  sub_data = top_addr[15:8];
      default: sub_data = 8'h00;
    endcase
  end

  assign drive  = (sel != SEL_PASS);
  assign sub_oe = bus_en && drive;
  assign prg_en = !drive;
endmodule

// File: rtl/osc_call_unit.sv
module osc_call_unit
  import osc_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DEPTH     = 4,
  parameter logic [15:0]     CART_BASE = 16'h6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              sync,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        prg_data,
  output logic [7:0]        sub_data,
  output logic              sub_oe,
  output logic              prg_en
);
  localparam int CW = $clog2(DEPTH + 1);

  logic              in_cart;
  logic              push, pop, nonempty, busy;
  logic [ADDR_W-1:0] top_addr;
  logic [CW-1:0]     count;
  sel_t              sel;

  assign in_cart = (cpu_addr >= ADDR_W'(CART_BASE));

  osc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .sync(sync),
    .in_cart(in_cart), .prg_data(prg_data), .nonempty(nonempty),
    .push(push), .pop(pop), .sel(sel), .busy(busy)
  );

  osc_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push),
    .push_addr(cpu_addr + ADDR_W'(3)), .pop(pop),
    .top_addr(top_addr), .nonempty(nonempty), .count(count)
  );

  osc_bus_mux #(.ADDR_W(ADDR_W)) u_mux (
    .bus_en(bus_en), .sel(sel), .top_addr(top_addr),
    .sub_data(sub_data), .sub_oe(sub_oe), .prg_en(prg_en)
  );
endmodule

// File: rtl/osc_call_unit_chk.sv
module osc_call_unit_chk #(
  parameter int          ADDR_W    = 16,
  parameter int          DEPTH     = 4,
  parameter logic [15:0] CART_BASE = 16'h6000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              sync,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [7:0]        prg_data,
  input logic [7:0]        sub_data,
  input logic              sub_oe,
  input logic              prg_en,
  input logic              busy,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  logic trig;
  assign trig = bus_en && sync && !busy && prg_data == 8'h02 &&
                cpu_addr >= ADDR_W'(CART_BASE);

  AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sub_oe && prg_en)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> !sub_oe); // R11
  AST_TRIG_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (sub_oe && sub_data == 8'h6C && !prg_en)); // R2
  AST_TRIG_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && count < DEPTH) |=> (count == $past(count) + 1'b1)); // R3
  AST_LOW_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && sync && !busy && cpu_addr < ADDR_W'(CART_BASE)) |-> !sub_oe); // R7
  AST_OPERAND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !sync && !busy) |-> (prg_en && !sub_oe)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH); // R10
endmodule

bind osc_call_unit osc_call_unit_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CART_BASE(CART_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .sync(sync),
  .cpu_addr(cpu_addr), .prg_data(prg_data), .sub_data(sub_data),
  .sub_oe(sub_oe), .prg_en(prg_en), .busy(busy), .count(count)
);

// File: tb/osc_call_unit_tb.sv
module osc_call_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        sync = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  prg_data = '0;
  logic [7:0]  sub_data;
  logic        sub_oe, prg_en;

  int total = 0;
  int bad = 0;
  logic [7:0] g_d;
  logic g_oe, g_pe;

  always #4 clk = ~clk;

  osc_call_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .sync(sync),
    .cpu_addr(cpu_addr), .prg_data(prg_data),
    .sub_data(sub_data), .sub_oe(sub_oe), .prg_en(prg_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic s, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = en; sync = s; cpu_addr = a; prg_data = d;
    #2;
    g_d = sub_data; g_oe = sub_oe; g_pe = prg_en;
  endtask

  task automatic expect_pass(input string req);
    chk(!g_oe && g_pe, req, {g_oe, g_pe}, 2'b01);
  endtask

  task automatic expect_sub(input string req, input logic [7:0] v);
    chk(g_oe && !g_pe && g_d == v, req, {g_oe, g_pe, g_d}, {2'b10, v});
  endtask

  task automatic do_call(input logic [15:0] a);
    cyc(1, 1, a, 8'h02);
    expect_sub("R2 indirect opcode", 8'h6C);
    cyc(1, 0, a + 16'd1, 8'h34);
    expect_pass("R4 pointer low");
    cyc(1, 0, a + 16'd2, 8'h12);
    expect_pass("R4 pointer high");
  endtask

  task automatic do_ret(input logic [15:0] a, input logic [15:0] ra);
    cyc(1, 1, a, 8'h60);
    expect_sub("R5 jmp opcode", 8'h4C);
    cyc(1, 0, a + 16'd1, 8'hEE);
    expect_sub("R3 R5 return low", ra[7:0]);
    cyc(1, 0, a + 16'd2, 8'hEE);
    expect_sub("R3 R5 return high", ra[15:8]);
  endtask

  task automatic ret_plain(input logic [15:0] a, input string req);
    cyc(1, 1, a, 8'h60);
    expect_pass(req);
    cyc(1, 0, a + 16'd1, 8'h00);
    expect_pass(req);
  endtask

  task automatic t_reset;
    cyc(0, 0, 16'h0000, 8'h00);
    chk(!g_oe && g_pe, "R1 reset outputs", {g_oe, g_pe}, 2'b01);
    ret_plain(16'h9000, "R1 R6 empty store after reset");
  endtask

  task automatic t_call_return;
    do_call(16'h8000);
    do_ret(16'hA000, 16'h8003);
    ret_plain(16'hA010, "R6 store empty after pop");
  endtask

  task automatic t_wrap;
    do_call(16'hFFFE);
    do_ret(16'hA020, 16'h0001);
  endtask

  task automatic t_low_space;
    cyc(1, 1, 16'h0300, 8'h02);
    expect_pass("R7 trigger below base");
    ret_plain(16'h9100, "R7 nothing pushed");
    do_call(16'h8100);
    ret_plain(16'h0400, "R7 return below base");
    do_ret(16'h9200, 16'h8103);
  endtask

  task automatic t_nonfetch;
    cyc(1, 0, 16'h8800, 8'h02);
    expect_pass("R8 operand 02");
    ret_plain(16'h9300, "R8 nothing pushed");
    do_call(16'h8200);
    cyc(1, 0, 16'h8900, 8'h60);
    expect_pass("R8 operand 60");
    do_ret(16'h9400, 16'h8203);
  endtask

  task automatic t_nested;
    do_call(16'h8300);
    do_call(16'hC000);
    do_ret(16'hD000, 16'hC003);
    do_ret(16'h8500, 16'h8303);
    ret_plain(16'h8600, "R9 store drained");
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 5; i++) do_call(16'h8000 + 16'(i * 16'h100));
    for (int i = 4; i >= 1; i--) do_ret(16'hE000, 16'h8003 + 16'(i * 16'h100));
    ret_plain(16'hE100, "R10 oldest dropped");
  endtask

  task automatic t_stall;
    do_call(16'h8700);
    cyc(1, 1, 16'hB000, 8'h60);
    expect_sub("R11 jmp opcode", 8'h4C);
    cyc(0, 0, 16'hB000, 8'h00);
    chk(!g_oe, "R11 idle cycle quiet", g_oe, 0);
    chk(!(g_oe && g_pe), "R12 exclusive", {g_oe, g_pe}, 2'b00);
    cyc(1, 0, 16'hB001, 8'h00);
    expect_sub("R11 low after idle", 8'h03);
    cyc(0, 0, 16'hB001, 8'h00);
    chk(!g_oe, "R11 idle cycle quiet", g_oe, 0);
    cyc(1, 0, 16'hB002, 8'h00);
    expect_sub("R11 high after idle", 8'h87);
    ret_plain(16'hB100, "R11 popped once");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_call_return();
    t_wrap();
    t_low_space();
    t_nonfetch();
    t_nested();
    t_overflow();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule